// File: doc/BRIEF.md
# Transceiver Mode and Loopback Controller

This block turns a 4-bit control word into the static controls of a byte-wide serial transceiver. These controls are a block-wide reset, two output-enable lines, a NAND-tree test enable, a frame-recovery disable, a loopback selection, and a clock configuration. The clock configuration has three fields: master or slave timing, STS-3 or STS-12 rate, and internal PLL or external-clock bypass. The control word is sampled on the byte clock, so every control takes effect one clock after the word is presented.

When bit 3 of the word is 0, the word selects one momentary function: reset, output disable, test, frame-recovery disable, or one of three loopbacks. That function stays active only while the word is held. When bit 3 is 1, the lower three bits are captured into a separate clock-mode register, and every momentary function goes back to its inactive state. The clock-mode register keeps its value across all momentary codes, so entering or leaving a loopback leaves the clock setup unchanged.

The registered loopback selection drives combinational routing multiplexers. These connect the serializer output, the deserializer input and the external serial pins. Data and clock are always switched together, for every lane.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs are `blk_rst_n`=1, `ttl_oe`=1, `refclk_oe`=1, `nand_test_en`=0, `frame_rec_dis`=0, `lpbk_sel`=00, and the clock mode {`sel_pll_normal`,`sel_sts12`,`sel_master`} is 111.
- R2: Control code 0h drives `blk_rst_n` low one clock after it is sampled. `blk_rst_n` returns high one clock after any other code is sampled.
- R3: Code 1h drives `ttl_oe` low and keeps `refclk_oe` high. Code 3h drives `refclk_oe` low and keeps `ttl_oe` high.
- R4: Code 2h raises `nand_test_en`. No other code raises it.
- R5: Code 4h raises `frame_rec_dis`. No other code raises it.
- R6: Codes 5h, 6h and 7h set `lpbk_sel` to 01 (equipment), 10 (facility) and 11 (split). All other codes set it to 00 (none).
- R7: A code with bit 3 = 1 is latched into the clock mode one clock after it is sampled: bit 0 goes to `sel_master`, bit 1 to `sel_sts12`, and bit 2 to `sel_pll_normal`.
- R8: Codes 0h–7h leave the clock mode unchanged.
- R9: A code with bit 3 = 1 returns every momentary control to its inactive level: `blk_rst_n`=1, both enables 1, test and frame-recovery disable 0, `lpbk_sel`=00.
- R10: With `lpbk_sel`=00, `pin_tx_data`/`pin_tx_clk` follow `ser_tx_data`/`ser_tx_clk`, and `deser_rx_data`/`deser_rx_clk` follow `pin_rx_data`/`pin_rx_clk`.
- R11: In equipment loopback, the deserializer input takes the serializer data and clock, and the transmit pins still carry the serializer output.
- R12: In facility loopback, the transmit pins carry the received pin data and clock, and the deserializer still takes the received pins.
- R13: In split loopback, both crossings apply at once: the deserializer takes the serializer output, and the transmit pins take the received pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl | input | 4 | Control word |
| ser_tx_data | input | LANES | Serializer output data |
| ser_tx_clk | input | LANES | Serializer output clock |
| pin_rx_data | input | LANES | Received serial data from pins |
| pin_rx_clk | input | LANES | Received serial clock from pins |
| deser_rx_data | output | LANES | Deserializer input data |
| deser_rx_clk | output | LANES | Deserializer input clock |
| pin_tx_data | output | LANES | Transmit serial data to pins |
| pin_tx_clk | output | LANES | Transmit serial clock to pins |
| blk_rst_n | output | 1 | Active-low reset to the transceiver |
| ttl_oe | output | 1 | Enable for general outputs |
| refclk_oe | output | 1 | Enable for reference clock output |
| nand_test_en | output | 1 | NAND-tree input test enable |
| frame_rec_dis | output | 1 | Frame recovery disable |
| lpbk_sel | output | 2 | Loopback selection (00 none, 01 equipment, 10 facility, 11 split) |
| sel_master | output | 1 | 1 = timing from reference, 0 = from receive clock |
| sel_sts12 | output | 1 | 1 = STS-12 rate, 0 = STS-3 |
| sel_pll_normal | output | 1 | 1 = internal PLL, 0 = external clock bypass |

## Verification
Several properties are checked on every cycle. The momentary controls are never active two at a time. A bit-3 code always returns them to idle. A low bit 3 never moves the clock mode. Each loopback setting routes the pins and the deserializer as specified. Other behaviour can only be shown by the bench's code sequences. These are the exact field mapping of each clock-mode code, the distinction between the three loopbacks, and the fact that the clock setup survives a run through every momentary code.

// File: rtl/xcvr_ctrl_pkg.sv
// Shared types and the control-word decode for the transceiver mode controller.
// Assumes a 4-bit control word: bit 3 high means a clock-mode code.
package xcvr_ctrl_pkg;

    localparam int CTRL_W = 4;
    localparam int MODE_W = CTRL_W - 1;

    typedef enum logic [1:0] {
        LPBK_NONE  = 2'b00,
        LPBK_EQUIP = 2'b01,
        LPBK_FACIL = 2'b10,
        LPBK_SPLIT = 2'b11
    } lpbk_e;

    typedef struct packed {
        logic  blk_rst_n;
        logic  ttl_oe;
        logic  refclk_oe;
        logic  nand_en;
        logic  frd;
        lpbk_e lpbk;
    } fn_ctrl_t;

    typedef struct packed {
        logic pll_normal;
        logic sts12;
        logic master;
    } clk_mode_t;

    localparam fn_ctrl_t FN_IDLE = '{blk_rst_n: 1'b1, ttl_oe: 1'b1, refclk_oe: 1'b1,
                                     nand_en: 1'b0, frd: 1'b0, lpbk: LPBK_NONE};

    // Map a control word to its momentary function controls.
    function automatic fn_ctrl_t decode_fn(input logic [CTRL_W-1:0] code);
        fn_ctrl_t f;
        f = FN_IDLE;
        if (!code[CTRL_W-1]) begin
            case (code[MODE_W-1:0])
                3'd0: f.blk_rst_n = 1'b0;
                3'd1: f.ttl_oe    = 1'b0;
                3'd2: f.nand_en   = 1'b1;
                3'd3: f.refclk_oe = 1'b0;
                3'd4: f.frd       = 1'b1;
                3'd5: f.lpbk      = LPBK_EQUIP;
                3'd6: f.lpbk      = LPBK_FACIL;
                default: f.lpbk   = LPBK_SPLIT;
            endcase
        end
        return f;
    endfunction

endpackage

// File: rtl/mode_decode.sv
// Registers the momentary function controls decoded from the control word.
// Assumes the control word meets setup/hold to clk; one clock of latency.
module mode_decode
    import xcvr_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl,
    output fn_ctrl_t          fn
);

    // Sample and decode the control word each byte clock.
    always_ff @(posedge clk) begin
        if (!rst_n) fn <= FN_IDLE;
        else        fn <= decode_fn(ctrl);
    end

    // R9
    clk_code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[CTRL_W-1] |=> (fn.blk_rst_n && fn.ttl_oe && fn.refclk_oe &&
                            !fn.nand_en && !fn.frd && fn.lpbk == LPBK_NONE));

    // R2
    reset_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl == '0) |=> !fn.blk_rst_n);

    // R3 R4 R5 R6: at most one momentary function at a time
    one_fn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!fn.blk_rst_n, !fn.ttl_oe, !fn.refclk_oe, fn.nand_en, fn.frd,
                  fn.lpbk != LPBK_NONE}));

endmodule

// File: rtl/clk_mode_latch.sv
// Holds the clock configuration; captures the low bits of a bit-3 code.
// Assumes momentary codes must never disturb the held configuration.
module clk_mode_latch
    import xcvr_ctrl_pkg::*;
#(
    parameter logic [MODE_W-1:0] RESET_MODE = 3'b111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl,
    output clk_mode_t         mode
);

    // Capture the clock setup while bit 3 is high, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                mode <= clk_mode_t'(RESET_MODE);
        else if (ctrl[CTRL_W-1])   mode <= '{pll_normal: ctrl[2], sts12: ctrl[1], master: ctrl[0]};
    end

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[CTRL_W-1] |=> $stable(mode));

    // R7
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[CTRL_W-1] |=> (mode.master == $past(ctrl[0]) && mode.sts12 == $past(ctrl[1])));

endmodule

// File: rtl/serial_route.sv
// Combinational loopback routing between serializer, deserializer and pins.
// Assumes data and clock of a lane always switch together.
module serial_route
    import xcvr_ctrl_pkg::*;
#(
    parameter int LANES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lpbk_e            lpbk,
    input  logic [LANES-1:0] ser_d,
    input  logic [LANES-1:0] ser_c,
    input  logic [LANES-1:0] rx_d,
    input  logic [LANES-1:0] rx_c,
    output logic [LANES-1:0] deser_d,
    output logic [LANES-1:0] deser_c,
    output logic [LANES-1:0] tx_d,
    output logic [LANES-1:0] tx_c
);

    logic to_deser_from_ser;
    logic to_pins_from_rx;

    // Which crossings the selected loopback enables.
    always_comb begin
        to_deser_from_ser = (lpbk == LPBK_EQUIP) || (lpbk == LPBK_SPLIT);
        to_pins_from_rx   = (lpbk == LPBK_FACIL) || (lpbk == LPBK_SPLIT);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Per-lane data and clock multiplexers.
        always_comb begin
            deser_d[g] = to_deser_from_ser ? ser_d[g] : rx_d[g];
            deser_c[g] = to_deser_from_ser ? ser_c[g] : rx_c[g];
            tx_d[g]    = to_pins_from_rx   ? rx_d[g]  : ser_d[g];
            tx_c[g]    = to_pins_from_rx   ? rx_c[g]  : ser_c[g];
        end
    end

    // R10
    normal_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lpbk == LPBK_NONE) |-> (tx_d == ser_d && tx_c == ser_c && deser_d == rx_d && deser_c == rx_c));

    // R11
    equip_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lpbk == LPBK_EQUIP) |-> (deser_d == ser_d && deser_c == ser_c && tx_d == ser_d));

    // R12
    facil_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lpbk == LPBK_FACIL) |-> (tx_d == rx_d && tx_c == rx_c && deser_d == rx_d));

    // R13
    split_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lpbk == LPBK_SPLIT) |-> (tx_c == rx_c && deser_c == ser_c));

endmodule

// File: rtl/xcvr_mode_ctrl.sv
// Top: control-word decode, latched clock configuration and loopback routing.
// Assumes ctrl is synchronous to clk; rst_n is synchronous, active low.
module xcvr_mode_ctrl
    import xcvr_ctrl_pkg::*;
#(
    parameter int LANES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       ctrl,
    input  logic [LANES-1:0] ser_tx_data,
    input  logic [LANES-1:0] ser_tx_clk,
    input  logic [LANES-1:0] pin_rx_data,
    input  logic [LANES-1:0] pin_rx_clk,
    output logic [LANES-1:0] deser_rx_data,
    output logic [LANES-1:0] deser_rx_clk,
    output logic [LANES-1:0] pin_tx_data,
    output logic [LANES-1:0] pin_tx_clk,
    output logic             blk_rst_n,
    output logic             ttl_oe,
    output logic             refclk_oe,
    output logic             nand_test_en,
    output logic             frame_rec_dis,
    output logic [1:0]       lpbk_sel,
    output logic             sel_master,
    output logic             sel_sts12,
    output logic             sel_pll_normal
);

    fn_ctrl_t  fn;
    clk_mode_t mode;

    mode_decode u_dec (.clk(clk), .rst_n(rst_n), .ctrl(ctrl), .fn(fn));

    clk_mode_latch #(.RESET_MODE(3'b111)) u_clk (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .mode(mode));

    serial_route #(.LANES(LANES)) u_route (
        .clk(clk), .rst_n(rst_n), .lpbk(fn.lpbk),
        .ser_d(ser_tx_data), .ser_c(ser_tx_clk),
        .rx_d(pin_rx_data), .rx_c(pin_rx_clk),
        .deser_d(deser_rx_data), .deser_c(deser_rx_clk),
        .tx_d(pin_tx_data), .tx_c(pin_tx_clk));

    // Drive the control outputs from the registered state.
    always_comb begin
        blk_rst_n      = fn.blk_rst_n;
        ttl_oe         = fn.ttl_oe;
        refclk_oe      = fn.refclk_oe;
        nand_test_en   = fn.nand_en;
        frame_rec_dis  = fn.frd;
        lpbk_sel       = fn.lpbk;
        sel_master     = mode.master;
        sel_sts12      = mode.sts12;
        sel_pll_normal = mode.pll_normal;
    end

endmodule

// File: tb/tb_xcvr_mode_ctrl.sv
module tb_xcvr_mode_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;

    // {code[3:0], blk_rst_n, ttl_oe, refclk_oe, nand, frd, lpbk[1:0], pll_normal, sts12, master}
    localparam logic [13:0] VEC [NVEC] = '{
        {4'h8, 10'b1110000000},
        {4'h5, 10'b1110001000},
        {4'h0, 10'b0110000000},
        {4'hD, 10'b1110000101},
        {4'h1, 10'b1010000101},
        {4'h2, 10'b1111000101},
        {4'h3, 10'b1100000101},
        {4'h4, 10'b1110100101},
        {4'h6, 10'b1110010101},
        {4'h7, 10'b1110011101},
        {4'hA, 10'b1110000010},
        {4'hF, 10'b1110000111},
        {4'h9, 10'b1110000001}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic [3:0] ctrl = 4'h8;
    logic ser_d = 0, ser_c = 0, rx_d = 0, rx_c = 0;
    logic deser_d, deser_c, tx_d, tx_c;
    logic blk_rst_n, ttl_oe, refclk_oe, nand_test_en, frame_rec_dis;
    logic [1:0] lpbk_sel;
    logic sel_master, sel_sts12, sel_pll_normal;
    int n_run = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xcvr_mode_ctrl #(.LANES(1)) dut (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl),
        .ser_tx_data(ser_d), .ser_tx_clk(ser_c),
        .pin_rx_data(rx_d), .pin_rx_clk(rx_c),
        .deser_rx_data(deser_d), .deser_rx_clk(deser_c),
        .pin_tx_data(tx_d), .pin_tx_clk(tx_c),
        .blk_rst_n(blk_rst_n), .ttl_oe(ttl_oe), .refclk_oe(refclk_oe),
        .nand_test_en(nand_test_en), .frame_rec_dis(frame_rec_dis),
        .lpbk_sel(lpbk_sel), .sel_master(sel_master), .sel_sts12(sel_sts12),
        .sel_pll_normal(sel_pll_normal));

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'h0: return "R2";
            4'h1, 4'h3: return "R3";
            4'h2: return "R4";
            4'h4: return "R5";
            4'h5, 4'h6, 4'h7: return "R6";
            default: return "R7/R9";
        endcase
    endfunction

    function automatic logic [9:0] outs();
        return {blk_rst_n, ttl_oe, refclk_oe, nand_test_en, frame_rec_dis, lpbk_sel,
                sel_pll_normal, sel_sts12, sel_master};
    endfunction

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // Apply a code at the falling edge and sample one clock later.
    task automatic apply(input logic [3:0] c);
        @(negedge clk) ctrl = c;
        @(negedge clk);
    endtask

    // Check the four routed outputs against expected {deser_d, deser_c, tx_d, tx_c}.
    task automatic route_chk(input string req, input logic [3:0] exp);
        #1;
        check(req, {6'b0, deser_d, deser_c, tx_d, tx_c}, {6'b0, exp});
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        ctrl = 4'h0;
        repeat (3) @(negedge clk);
        // R1: reset state even though code 0h is presented
        check("R1", outs(), 10'b1110000111);
        rst_n = 1;
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][13:10]);
            check(req_of(VEC[i][13:10]), outs(), VEC[i][9:0]);
        end

        // R8: sweep every momentary code, clock mode 001 must survive
        for (int c = 0; c < 8; c++) begin
            apply(4'(c));
            check("R8", {7'b0, sel_pll_normal, sel_sts12, sel_master}, 10'b0000000001);
        end
        // R2: reset released one clock after leaving 0h
        apply(4'h0);
        check("R2", {9'b0, blk_rst_n}, 10'b0);
        apply(4'hE);
        check("R2", {9'b0, blk_rst_n}, 10'b1);
        check("R7", {7'b0, sel_pll_normal, sel_sts12, sel_master}, 10'b0000000110);

        // R10: normal routing
        apply(4'hE);
        ser_d = 1; ser_c = 0; rx_d = 0; rx_c = 1;
        route_chk("R10", 4'b0110);
        ser_d = 0; ser_c = 1; rx_d = 1; rx_c = 0;
        route_chk("R10", 4'b1001);
        // R11: equipment loopback
        apply(4'h5);
        route_chk("R11", 4'b0101);
        ser_d = 1; ser_c = 0; rx_d = 0; rx_c = 1;
        route_chk("R11", 4'b1010);
        // R12: facility loopback
        apply(4'h6);
        route_chk("R12", 4'b0101);
        ser_d = 0; ser_c = 1; rx_d = 1; rx_c = 0;
        route_chk("R12", 4'b1010);
        // R13: split loopback
        apply(4'h7);
        route_chk("R13", 4'b0110);
        ser_d = 1; ser_c = 0; rx_d = 0; rx_c = 1;
        route_chk("R13", 4'b1001);
        // R9: leaving loopback with a clock code restores normal routing
        apply(4'hC);
        route_chk("R9", 4'b0110);
        check("R9", outs(), 10'b1110000100);

        // R1: mid-run reset restores defaults
        @(negedge clk) rst_n = 0; ctrl = 4'h5;
        @(negedge clk);
        check("R1", outs(), 10'b1110000111);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule